// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Offset Trim

This block is the digital sequencer for one successive-approximation ADC that serves a pair of pixel columns. A row pulse starts two conversions, one right after the other: first the even column, then the odd one. Each conversion searches a binary-weighted capacitor DAC one trial bit per clock, starting at the MSB. The comparator compares the signal side against a reference side whose weight roughly equals the sum of the binary weights. The block samples the comparator decision once per step and builds the output code from those decisions. When a conversion ends, a one-cycle valid strobe marks the result, and a tag tells which column it belongs to.

The comparator offset is cancelled by a small trim DAC, and this block holds the trim code. A frame pulse starts an automatic calibration with the inputs shorted. That calibration is a binary search over the trim code, MSB first, and it tracks slow drift from frame to frame. A three-wire serial port (active-low select, clock, data) can also read and write the trim code and a lock flag. Each column group answers only to its own address. While the lock flag is set, the automatic search is suppressed and a written value stays in force.

Top module: `sar_cal_ctrl`

## Requirements
- R1: After a row pulse is taken, result_valid_o rises exactly RES_W clock edges after the edge that sampled the pulse, with exactly RES_W comparator decisions used. It is low one cycle earlier.
- R2: The first trial code on dac_code_o after a conversion starts has only the MSB set. The trial bits then resolve from MSB to LSB, one per clock.
- R3: A trial bit is kept when cmp_i is 1 (input at or above DAC) and cleared otherwise. The result is the largest code the comparator accepts, so it saturates at 0 and at 2^RES_W-1.
- R4: Each taken row pulse gives two one-cycle result strobes. The even column comes first with conv_odd_o=0. The odd column follows RES_W+1 cycles later with conv_odd_o=1.
- R5: A row or frame pulse that arrives while the block is busy is ignored. It neither disturbs the ongoing results nor adds a strobe.
- R6: A frame pulse taken while idle and unlocked raises cal_short_o for exactly TRIM_W+1 cycles. During that window the trim code is searched MSB first, and a trial bit is kept when cmp_i is 0. The result is the largest code for which the comparator still reports 0, or 0 if there is none. The result is then held on trim_o.
- R7: While the lock flag is set, a frame pulse starts no calibration and trim_o is unchanged.
- R8: A serial write frame holds, MSB first while cs_ni is low: a read/write bit (0 = write), ADDR_W address bits, the lock bit, and TRIM_W data bits, sampled on rising sck_i. If the address equals GROUP_ADDR, the frame loads the trim code and the lock flag.
- R9: In a read frame (first bit 1) to the block's address, sdo_o presents the lock flag and then the trim code MSB first. Each bit is available before the rising clock of the frame positions that follow the address. While deselected, sdo_o is 0.
- R10: A frame to another address, or a frame cut short before its last bit, changes neither the trim code nor the lock flag.
- R11: After reset the trim code is mid-scale (only its MSB set), the lock flag is 0, and busy_o, cal_short_o, result_valid_o and sdo_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame pulse, requests a calibration |
| row_start_i | input | 1 | Row pulse, requests two conversions |
| cmp_i | input | 1 | Comparator decision |
| dac_code_o | output | RES_W | Trial code to the capacitor DAC; final code while result_valid_o |
| result_o | output | RES_W | Conversion result, meaningful while result_valid_o |
| result_valid_o | output | 1 | One-cycle strobe per result |
| conv_odd_o | output | 1 | Column under conversion; tags the result |
| trim_o | output | TRIM_W | Code for the comparator trim DAC |
| cal_short_o | output | 1 | Inputs shorted, calibration running |
| busy_o | output | 1 | Calibration or conversion in progress |
| cs_ni | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |

## Verification
The bench builds the block with RES_W=6, TRIM_W=4, ADDR_W=3 and GROUP_ADDR=5. These widths make it practical to convert every one of the 64 input codes for both columns. They also let calibration run across a comparator-offset range that drives the trim search past both ends of its 16 codes. Manual trim values push the conversion into both saturation limits. The 9-bit serial frames are short enough to cover a matching address, a foreign address and a truncated frame.

// File: rtl/sar_cal_pkg.sv
package sar_cal_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CAL  = 2'd1,
    SEQ_CONV = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sar_search_eng.sv
module sar_search_eng #(
  parameter int unsigned W        = 10,
  parameter bit          KEEP_LVL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         cmp_i,
  output logic [W-1:0] code_o,
  output logic         done_o
);
  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};
  localparam int unsigned SW = $clog2(W + 1);

  logic [W-1:0] code_q, mask_q, resolved;
  logic         busy_q, done_q, keep;
  logic [SW-1:0] steps_q;

  always_comb begin
    keep     = (cmp_i == KEEP_LVL);
    resolved = keep ? code_q : (code_q & ~mask_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mask_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        code_q <= TOP;
        mask_q <= TOP;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (mask_q[0]) begin
          code_q <= resolved;
          mask_q <= '0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          code_q <= resolved | (mask_q >> 1);
          mask_q <= mask_q >> 1;
        end
      end
    end
  end

  // step count kept only for the checks below
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                steps_q <= '0;
    else if (start_i && !busy_q) steps_q <= '0;
    else if (busy_q)            steps_q <= steps_q + 1'b1;
  end

  assign code_o = code_q;
  assign done_o = done_q;

  // R1
  step_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (steps_q == SW'(W)));
  // R2
  one_trial_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mask_q));
  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_start_i,
  input  logic       row_start_i,
  input  logic       lock_i,
  input  logic       cal_done_i,
  input  logic       conv_done_i,
  output logic       cal_start_o,
  output logic       conv_start_o,
  output seq_state_e state_o,
  output logic       odd_o
);
  seq_state_e state_q;
  logic       odd_q;

  always_comb begin
    cal_start_o  = (state_q == SEQ_IDLE) && frame_start_i && !lock_i;
    conv_start_o = ((state_q == SEQ_IDLE) && !cal_start_o && row_start_i) ||
                   ((state_q == SEQ_CONV) && conv_done_i && !odd_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      odd_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (cal_start_o) state_q <= SEQ_CAL;
          else if (row_start_i) begin
            state_q <= SEQ_CONV;
            odd_q   <= 1'b0;
          end
        end
        SEQ_CAL: if (cal_done_i) state_q <= SEQ_IDLE;
        SEQ_CONV: begin
          if (conv_done_i) begin
            if (!odd_q) odd_q <= 1'b1;
            else begin
              odd_q   <= 1'b0;
              state_q <= SEQ_IDLE;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign odd_o   = odd_q;

  // R7
  locked_no_cal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE && lock_i) |=> (state_q != SEQ_CAL));
  // R5
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_CONV && !conv_done_i) |=> (state_q == SEQ_CONV));
endmodule

// File: rtl/sar_trim_port.sv
module sar_trim_port #(
  parameter int unsigned TRIM_W     = 6,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned GROUP_ADDR = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic              cal_load_i,
  input  logic [TRIM_W-1:0] cal_val_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              lock_o
);
  localparam int unsigned FRAME = 2 + ADDR_W + TRIM_W;
  localparam int unsigned CW    = $clog2(FRAME + 1);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(GROUP_ADDR);

  logic [1:0]        cs_sq, sck_sq, sdi_sq;
  logic              sck_d, rise, cs_act;
  logic [CW-1:0]     cnt_q;
  logic [FRAME-2:0]  in_sr;
  logic [FRAME-1:0]  word;
  logic [TRIM_W:0]   rd_sr;
  logic              rd_en;
  logic              hdr_hit, wr_hit;
  logic [TRIM_W-1:0] trim_q;
  logic              lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sq  <= 2'b11;
      sck_sq <= 2'b00;
      sdi_sq <= 2'b00;
      sck_d  <= 1'b0;
    end else begin
      cs_sq  <= {cs_sq[0], cs_ni};
      sck_sq <= {sck_sq[0], sck_i};
      sdi_sq <= {sdi_sq[0], sdi_i};
      sck_d  <= sck_sq[1];
    end
  end

  always_comb begin
    rise    = sck_sq[1] & ~sck_d;
    cs_act  = ~cs_sq[1];
    word    = {in_sr, sdi_sq[1]};
    hdr_hit = cs_act && rise && (cnt_q == CW'(ADDR_W)) && word[ADDR_W] &&
              (word[ADDR_W-1:0] == MY_ADDR);
    wr_hit  = cs_act && rise && (cnt_q == CW'(FRAME - 1)) && !word[FRAME-1] &&
              (word[FRAME-2 -: ADDR_W] == MY_ADDR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      in_sr <= '0;
      rd_sr <= '0;
      rd_en <= 1'b0;
    end else if (!cs_act) begin
      cnt_q <= '0;
      rd_en <= 1'b0;
    end else if (rise) begin
      if (cnt_q != CW'(FRAME)) cnt_q <= cnt_q + 1'b1;
      in_sr <= word[FRAME-2:0];
      if (hdr_hit) begin
        rd_en <= 1'b1;
        rd_sr <= {lock_q, trim_q};
      end else begin
        rd_sr <= {rd_sr[TRIM_W-1:0], 1'b0};
      end
    end
  end

  // host write has priority over the calibration result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trim_q <= {1'b1, {(TRIM_W-1){1'b0}}};
      lock_q <= 1'b0;
    end else if (wr_hit) begin
      trim_q <= word[TRIM_W-1:0];
      lock_q <= word[TRIM_W];
    end else if (cal_load_i && !lock_q) begin
      trim_q <= cal_val_i;
    end
  end

  assign sdo_o  = rd_en & rd_sr[TRIM_W];
  assign trim_o = trim_q;
  assign lock_o = lock_q;

  // R7
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !wr_hit) |=> $stable(trim_q));
  // R9
  sdo_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_sq[1] && $past(cs_sq[1])) |-> !sdo_o);
endmodule

// File: rtl/sar_cal_ctrl.sv
module sar_cal_ctrl
  import sar_cal_pkg::*;
#(
  parameter int unsigned RES_W      = 10,
  parameter int unsigned TRIM_W     = 6,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned GROUP_ADDR = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              row_start_i,
  input  logic              cmp_i,
  output logic [RES_W-1:0]  dac_code_o,
  output logic [RES_W-1:0]  result_o,
  output logic              result_valid_o,
  output logic              conv_odd_o,
  output logic [TRIM_W-1:0] trim_o,
  output logic              cal_short_o,
  output logic              busy_o,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sdo_o
);
  seq_state_e        state;
  logic              odd, lock;
  logic              cal_start, conv_start, cal_done, conv_done;
  logic [RES_W-1:0]  conv_code;
  logic [TRIM_W-1:0] cal_code, trim_reg;

  sar_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .row_start_i  (row_start_i),
    .lock_i       (lock),
    .cal_done_i   (cal_done),
    .conv_done_i  (conv_done),
    .cal_start_o  (cal_start),
    .conv_start_o (conv_start),
    .state_o      (state),
    .odd_o        (odd)
  );

  sar_search_eng #(.W(RES_W), .KEEP_LVL(1'b1)) u_conv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(conv_start),
    .cmp_i  (cmp_i),
    .code_o (conv_code),
    .done_o (conv_done)
  );

  sar_search_eng #(.W(TRIM_W), .KEEP_LVL(1'b0)) u_cal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(cal_start),
    .cmp_i  (cmp_i),
    .code_o (cal_code),
    .done_o (cal_done)
  );

  sar_trim_port #(.TRIM_W(TRIM_W), .ADDR_W(ADDR_W), .GROUP_ADDR(GROUP_ADDR)) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .sck_i     (sck_i),
    .sdi_i     (sdi_i),
    .sdo_o     (sdo_o),
    .cal_load_i(cal_done),
    .cal_val_i (cal_code),
    .trim_o    (trim_reg),
    .lock_o    (lock)
  );

  assign cal_short_o    = (state == SEQ_CAL);
  assign trim_o         = cal_short_o ? cal_code : trim_reg;
  assign busy_o         = (state != SEQ_IDLE);
  assign dac_code_o     = conv_code;
  assign result_o       = conv_code;
  assign result_valid_o = conv_done;
  assign conv_odd_o     = odd;

  // R4
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);
  // R6
  short_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cal_short_o && result_valid_o));
  // R4
  valid_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> busy_o);
endmodule

// File: tb/sar_cal_ctrl_test.sv
`timescale 1ns/1ps
module sar_cal_ctrl_test;
  localparam int RW = 6;
  localparam int TW = 4;
  localparam int AW = 3;
  localparam int GA = 5;
  localparam int FR = 2 + AW + TW;
  localparam int RMAX = (1 << RW) - 1;
  localparam int TMAX = (1 << TW) - 1;
  localparam int TMID = 1 << (TW - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame = 1'b0, row = 1'b0, cmp;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [RW-1:0] dac_code, result;
  logic [TW-1:0] trim;
  logic valid, odd, cal_short, busy, sdo;

  int checks = 0, fails = 0;
  int off = 0, cur_trim = TMID;
  int vin_a = 0, vin_b = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  sar_cal_ctrl #(.RES_W(RW), .TRIM_W(TW), .ADDR_W(AW), .GROUP_ADDR(GA)) uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame), .row_start_i(row),
    .cmp_i(cmp), .dac_code_o(dac_code), .result_o(result),
    .result_valid_o(valid), .conv_odd_o(odd), .trim_o(trim),
    .cal_short_o(cal_short), .busy_o(busy), .cs_ni(cs_n), .sck_i(sck),
    .sdi_i(sdi), .sdo_o(sdo)
  );

  // behavioural comparator with offset and trim
  always_comb begin
    int x;
    x = (odd ? vin_b : vin_a) + off + int'(trim) - (TMID - 1);
    if (cal_short) cmp = (int'(trim) + off) >= TMID;
    else           cmp = x >= int'(dac_code);
  end

  function automatic int clampi(input int v, input int hi);
    return (v < 0) ? 0 : ((v > hi) ? hi : v);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ser(input logic [FR-1:0] w, input int nb, output logic [FR-1:0] rd);
    rd = '0;
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sdi = w[FR-1-i];
      repeat (3) @(negedge clk);
      rd[FR-1-i] = sdo;
      sck = 1'b1;
      repeat (6) @(negedge clk);
      sck = 1'b0;
      repeat (3) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [FR-1:0] wframe(input int addr, input int lk, input int data);
    return {1'b0, AW'(addr), 1'(lk), TW'(data)};
  endfunction

  function automatic logic [FR-1:0] rframe(input int addr);
    return {1'b1, AW'(addr), {(TW+1){1'b0}}};
  endfunction

  task automatic read_chk(input string req, input int addr, input int exp);
    logic [FR-1:0] rd;
    ser(rframe(addr), FR, rd);
    chk(req, int'(rd[TW:0]), exp);
  endtask

  task automatic run_cal(input bit locked);
    int n;
    @(negedge clk); frame = 1'b1;
    @(negedge clk); frame = 1'b0;
    n = 0;
    while (cal_short && n < 100) begin
      n++;
      @(negedge clk);
    end
    if (!locked) begin
      cur_trim = clampi(TMID - 1 - off, TMAX);
      chk("R6 shorted-window length", n, TW + 1);
      chk("R6 calibrated trim", int'(trim), cur_trim);
    end else begin
      chk("R7 no calibration when locked", n, 0);
      chk("R7 trim held when locked", int'(trim), cur_trim);
    end
  endtask

  task automatic run_row(input int va, input int vb, input bit poke);
    int ea, eb, extra;
    ea = clampi(va + off + cur_trim - (TMID - 1), RMAX);
    eb = clampi(vb + off + cur_trim - (TMID - 1), RMAX);
    vin_a = va; vin_b = vb;
    @(negedge clk); row = 1'b1;
    @(negedge clk); row = 1'b0;
    chk("R2 first trial is MSB", int'(dac_code), 1 << (RW - 1));
    for (int k = 1; k <= RW; k++) begin
      @(negedge clk);
      if (poke && k == 3) begin row = 1'b1; frame = 1'b1; end
      else begin row = 1'b0; frame = 1'b0; end
      if (k == RW - 1) chk("R1 valid not early", int'(valid), 0);
    end
    chk("R1 valid after RES_W steps", int'(valid), 1);
    chk("R3 even result", int'(result), ea);
    chk("R4 even tag", int'(odd), 0);
    for (int j = 1; j <= RW + 1; j++) begin
      @(negedge clk);
      if (j == 1) chk("R4 single-cycle strobe", int'(valid), 0);
    end
    chk("R4 odd strobe", int'(valid), 1);
    chk("R4 odd tag", int'(odd), 1);
    chk("R3 odd result", int'(result), eb);
    if (poke) begin
      extra = 0;
      for (int j = 0; j < 40; j++) begin
        @(negedge clk);
        if (valid) extra++;
      end
      chk("R5 no extra strobes", extra, 0);
      chk("R5 idle after pair", int'(busy), 0);
    end else begin
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [FR-1:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 trim mid-scale", int'(trim), TMID);
    chk("R11 valid low", int'(valid), 0);
    chk("R11 busy low", int'(busy), 0);
    chk("R11 shorted low", int'(cal_short), 0);
    chk("R11 sdo low", int'(sdo), 0);
    read_chk("R9 R11 readback after reset", GA, TMID);

    // R6 calibration across offsets, both ends of the trim range
    for (int o = -10; o <= 10; o++) begin
      off = o;
      run_cal(1'b0);
    end

    // R1 R2 R3 R4 exhaustive conversion sweep with calibrated trim
    off = 3;
    run_cal(1'b0);
    for (int v = 0; v <= RMAX; v++) run_row(v, RMAX - v, 1'b0);

    // R5 pulses while busy
    run_row(17, 40, 1'b1);

    // R8 R9 manual write with lock
    ser(wframe(GA, 1, 12), FR, rd);
    cur_trim = 12;
    chk("R8 written trim", int'(trim), 12);
    read_chk("R9 readback lock and trim", GA, (1 << TW) | 12);
    chk("R9 sdo low when deselected", int'(sdo), 0);
    run_cal(1'b1);
    // R3 saturation high: x = v + 3 + 12 - 7
    run_row(60, 50, 1'b0);

    // R10 foreign address and truncated frame
    ser(wframe(2, 0, 3), FR, rd);
    chk("R10 foreign write ignored", int'(trim), 12);
    ser(wframe(GA, 0, 3), FR - 3, rd);
    chk("R10 short frame ignored", int'(trim), 12);
    ser(rframe(2), FR, rd);
    chk("R10 foreign read silent", int'(rd), 0);
    read_chk("R10 lock kept", GA, (1 << TW) | 12);

    // R3 saturation low with locked zero trim
    ser(wframe(GA, 1, 0), FR, rd);
    cur_trim = 0;
    off = -2;
    run_row(4, 20, 1'b0);

    // R8 unlock then calibration resumes
    ser(wframe(GA, 0, 1), FR, rd);
    cur_trim = 1;
    chk("R8 unlocked write", int'(trim), 1);
    off = -4;
    run_cal(1'b0);
    read_chk("R9 readback after calibration", GA, cur_trim);

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule